// File: doc/BRIEF.md
# BCD Real-Time Clock and Calendar

This block keeps wall-clock time (hours, minutes, seconds) and a calendar date (century, year, month, day of month, weekday) as packed BCD digits. Every digit advances on an external one-second strobe. Software reaches it through a 32-bit register port. To load a new time or date, software first raises an update request. It then waits for the acknowledge flag, which shows that counting has frozen. It writes the new values and drops the request, and counting resumes.

A programmable alarm compares only the fields whose enable bits are set. Five event flags (acknowledge, alarm, second, minute rollover, day rollover) are cleared by writing ones. Each flag has a mask bit, and the unmasked flags are ORed onto one interrupt line. Written values are checked for BCD legality and range. A rejected value is flagged and is not loaded. Only 24-hour operation exists.

The register port accepts one request per cycle and never applies back-pressure: `req_ready` is high whenever the block is out of reset. A read returns its data on `rsp_rdata` in the following cycle with `rsp_valid` high for exactly that cycle. Writes produce no response. The port has no response-side ready, so the requester must take the data when `rsp_valid` is high.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time word reads 0x00000000, the calendar word reads 0x01210020 (century 20, year 00, month 01, weekday 1, date 01), and status, mask, valid-entry and `irq` are all zero.
- R2: An accepted tick (`tick_1hz` high while both request bits are clear) advances seconds. Seconds wrap from 59 to 00 with a minute carry, minutes wrap from 59 to 00 with an hour carry, and hours wrap from 23 to 00. The time word (offset 0x08) holds seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16. Bit 22 always reads 0.
- R3: On an hour wrap the date advances. The day of month rolls to 01 after 30 in months 04/06/09/11, after 28 or 29 in month 02 (29 when the binary year is divisible by 4, century ignored), and after 31 otherwise. Month 12 rolls to 01 and increments the year, year 99 rolls to 00 and increments the century, and the weekday rolls from 7 to 1. The calendar word (offset 0x0C) holds century in bits 6:0, year in bits 15:8, month in bits 20:16, weekday in bits 23:21 and day of month in bits 29:24.
- R4: Control word (offset 0x00) bit 0 requests a time update and bit 1 requests a calendar update. While either bit is set, ticks do not advance the clock. The first tick after a request sets status bit 0 (acknowledge). Writing both bits to zero resumes counting.
- R5: A write to the time word takes effect only while acknowledged with control bit 0 set. A write to the calendar word takes effect only while acknowledged with control bit 1 set. Any other such write leaves the counters unchanged.
- R6: A time or calendar write containing a non-BCD digit or an out-of-range field (including a day beyond the month length) is not loaded and sets valid-entry (offset 0x2C) bit 0 or bit 1. A rejected alarm write sets bit 2 (time alarm) or bit 3 (calendar alarm), and only enabled alarm fields are checked. A legal write of the same kind clears the bit.
- R7: The time alarm (offset 0x10) has field enables at bit 7 (seconds), bit 15 (minutes) and bit 23 (hours). The calendar alarm (offset 0x14) has enables at bit 23 (month) and bit 31 (day of month). After an accepted tick, status bit 1 sets if at least one field is enabled and every enabled field equals the new count.
- R8: Status bit 2 sets on every accepted tick, bit 3 when seconds wrap (minute rollover), and bit 4 when the day rolls over.
- R9: Writing to the status-clear word (offset 0x1C) clears exactly the status bits written as one. Status reads at offset 0x18.
- R10: A write to offset 0x20 sets the mask bits written as one, and a write to offset 0x24 clears them. The mask reads at offset 0x28. `irq` is high while any status bit has its mask bit set.
- R11: `req_ready` is high out of reset. A read returns data one cycle later with a single-cycle `rsp_valid`. The mode word (offset 0x04) and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe per elapsed second |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (no back-pressure) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Masked OR of the status flags |

## Verification
The hardest states to reach are the calendar boundaries: month ends in a leap and a common year, and the December 31 / year 99 rollover. Waiting for them by ticking would take millions of seconds. The bench therefore uses the update handshake to load 23:59:59 together with the date just before each boundary, and then issues a single tick. The frozen-counter condition is reached the same way. The bench raises a request, lets the acknowledging tick arrive, and then probes that further ticks and out-of-order writes leave the registers untouched.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned ADDR_W = 6;
  parameter int unsigned EVT_W  = 5;
  parameter int unsigned BAD_W  = 4;

  localparam int unsigned EV_ACK   = 0;
  localparam int unsigned EV_ALARM = 1;
  localparam int unsigned EV_SEC   = 2;
  localparam int unsigned EV_MIN   = 3;
  localparam int unsigned EV_DAY   = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_TIME  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_CAL   = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_TALM  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_CALM  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFS_CLR   = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] OFS_MSET  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] OFS_MCLR  = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] OFS_BAD   = ADDR_W'('h2C);

  typedef struct packed {
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } clock_t;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] wday;
    logic [7:0] mday;
  } date_t;

  // Next BCD value, wrapping from last back to first.
  function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] first,
                                          input logic [7:0] last);
    if (v == last) return first;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic bcd_in(input logic [7:0] v, input logic [7:0] lo, input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [7:0] bin;
    bin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] clock_to_word(input clock_t c);
    return {9'd0, 1'b0, c.hour[5:0], 1'b0, c.min[6:0], 1'b0, c.sec[6:0]};
  endfunction

  function automatic clock_t word_to_clock(input logic [WORD_W-1:0] w);
    clock_t c;
    c.hour = {2'b00, w[21:16]};
    c.min  = {1'b0, w[14:8]};
    c.sec  = {1'b0, w[6:0]};
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] date_to_word(input date_t d);
    return {2'b00, d.mday[5:0], d.wday[2:0], d.month[4:0], d.year, 1'b0, d.cent[6:0]};
  endfunction

  function automatic date_t word_to_date(input logic [WORD_W-1:0] w);
    date_t d;
    d.mday  = {2'b00, w[29:24]};
    d.wday  = {5'd0, w[23:21]};
    d.month = {3'd0, w[20:16]};
    d.year  = w[15:8];
    d.cent  = {1'b0, w[6:0]};
    return d;
  endfunction

  function automatic logic clock_ok(input clock_t c);
    return bcd_in(c.sec, 8'h00, 8'h59) && bcd_in(c.min, 8'h00, 8'h59) &&
           bcd_in(c.hour, 8'h00, 8'h23);
  endfunction

  function automatic logic date_ok(input date_t d);
    return bcd_in(d.cent, 8'h00, 8'h99) && bcd_in(d.year, 8'h00, 8'h99) &&
           bcd_in(d.month, 8'h01, 8'h12) && bcd_in(d.wday, 8'h01, 8'h07) &&
           bcd_in(d.mday, 8'h01, month_last(d.month, d.year));
  endfunction
endpackage

// File: rtl/rtc_clock_cnt.sv
module rtc_clock_cnt
  import rtc_pkg::*;
#(
  parameter clock_t RESET_VAL = '0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step,
  input  logic   load,
  input  clock_t load_val,
  output clock_t now,
  output logic   min_wrap,
  output logic   day_wrap
);
  logic sec_last, min_last, hour_last;

  assign sec_last  = (now.sec == 8'h59);
  assign min_last  = (now.min == 8'h59);
  assign hour_last = (now.hour == 8'h23);
  assign min_wrap  = step && sec_last;
  assign day_wrap  = min_wrap && min_last && hour_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now <= RESET_VAL;
    end else if (load) begin
      now <= load_val;
    end else if (step) begin
      now.sec <= bcd_next(now.sec, 8'h00, 8'h59);
      if (sec_last) now.min <= bcd_next(now.min, 8'h00, 8'h59);
      if (sec_last && min_last) now.hour <= bcd_next(now.hour, 8'h00, 8'h23);
    end
  end
endmodule

// File: rtl/rtc_date_cnt.sv
module rtc_date_cnt
  import rtc_pkg::*;
#(
  parameter date_t RESET_VAL = '{cent: 8'h20, year: 8'h00, month: 8'h01, wday: 8'h01, mday: 8'h01}
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  load,
  input  date_t load_val,
  output date_t now
);
  logic mday_last, month_last_q, year_last;

  assign mday_last    = (now.mday == month_last(now.month, now.year));
  assign month_last_q = (now.month == 8'h12);
  assign year_last    = (now.year == 8'h99);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now <= RESET_VAL;
    end else if (load) begin
      now <= load_val;
    end else if (step) begin
      now.wday <= bcd_next(now.wday, 8'h01, 8'h07);
      now.mday <= mday_last ? 8'h01 : bcd_next(now.mday, 8'h01, 8'h31);
      if (mday_last) now.month <= bcd_next(now.month, 8'h01, 8'h12);
      if (mday_last && month_last_q) now.year <= bcd_next(now.year, 8'h00, 8'h99);
      if (mday_last && month_last_q && year_last) now.cent <= bcd_next(now.cent, 8'h00, 8'h99);
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
(
  input  clock_t            now_clk,
  input  date_t             now_date,
  input  logic [WORD_W-1:0] talm,
  input  logic [WORD_W-1:0] calm,
  output logic              hit
);
  logic en_sec, en_min, en_hour, en_mon, en_mday;
  logic eq_sec, eq_min, eq_hour, eq_mon, eq_mday;

  assign en_sec  = talm[7];
  assign en_min  = talm[15];
  assign en_hour = talm[23];
  assign en_mon  = calm[23];
  assign en_mday = calm[31];

  assign eq_sec  = (talm[6:0]   == now_clk.sec[6:0]);
  assign eq_min  = (talm[14:8]  == now_clk.min[6:0]);
  assign eq_hour = (talm[21:16] == now_clk.hour[5:0]);
  assign eq_mon  = (calm[20:16] == now_date.month[4:0]);
  assign eq_mday = (calm[29:24] == now_date.mday[5:0]);

  assign hit = (en_sec | en_min | en_hour | en_mon | en_mday) &&
               (!en_sec  || eq_sec)  && (!en_min || eq_min) && (!en_hour || eq_hour) &&
               (!en_mon  || eq_mon)  && (!en_mday || eq_mday);
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              irq
);
  logic [1:0]        upd_req;
  logic              halted;
  logic [EVT_W-1:0]  status, mask, ev_set;
  logic [BAD_W-1:0]  bad_entry;
  logic [WORD_W-1:0] talm_q, calm_q, rd_mux;
  logic              step, step_q, alarm_hit, min_wrap, day_wrap;
  logic              wr_en, rd_en, load_clk, load_date;
  clock_t            cur_clk, new_clk;
  date_t             cur_date, new_date;

  assign wr_en     = req_valid && req_write;
  assign rd_en     = req_valid && !req_write;
  assign req_ready = rst_n;
  assign step      = tick_1hz && (upd_req == 2'b00);
  assign new_clk   = word_to_clock(req_wdata);
  assign new_date  = word_to_date(req_wdata);
  assign load_clk  = wr_en && (req_addr == OFS_TIME) && halted && upd_req[0] && clock_ok(new_clk);
  assign load_date = wr_en && (req_addr == OFS_CAL) && halted && upd_req[1] && date_ok(new_date);

  rtc_clock_cnt u_clock (
    .clk(clk), .rst_n(rst_n), .step(step), .load(load_clk), .load_val(new_clk),
    .now(cur_clk), .min_wrap(min_wrap), .day_wrap(day_wrap)
  );

  rtc_date_cnt u_date (
    .clk(clk), .rst_n(rst_n), .step(day_wrap), .load(load_date), .load_val(new_date),
    .now(cur_date)
  );

  rtc_alarm_cmp u_alarm (
    .now_clk(cur_clk), .now_date(cur_date), .talm(talm_q), .calm(calm_q), .hit(alarm_hit)
  );

  function automatic logic talm_ok(input logic [WORD_W-1:0] w);
    return (!w[7]  || bcd_in({1'b0, w[6:0]}, 8'h00, 8'h59)) &&
           (!w[15] || bcd_in({1'b0, w[14:8]}, 8'h00, 8'h59)) &&
           (!w[23] || bcd_in({2'b00, w[21:16]}, 8'h00, 8'h23));
  endfunction

  function automatic logic calm_ok(input logic [WORD_W-1:0] w);
    return (!w[23] || bcd_in({3'd0, w[20:16]}, 8'h01, 8'h12)) &&
           (!w[31] || bcd_in({2'b00, w[29:24]}, 8'h01, 8'h31));
  endfunction

  always_comb begin
    ev_set           = '0;
    ev_set[EV_ACK]   = tick_1hz && (upd_req != 2'b00) && !halted;
    ev_set[EV_ALARM] = step_q && alarm_hit;
    ev_set[EV_SEC]   = step;
    ev_set[EV_MIN]   = min_wrap;
    ev_set[EV_DAY]   = day_wrap;
  end

  always_comb begin
    case (req_addr)
      OFS_CTRL: rd_mux = {{(WORD_W-2){1'b0}}, upd_req};
      OFS_TIME: rd_mux = clock_to_word(cur_clk);
      OFS_CAL:  rd_mux = date_to_word(cur_date);
      OFS_TALM: rd_mux = talm_q;
      OFS_CALM: rd_mux = calm_q;
      OFS_STAT: rd_mux = {{(WORD_W-EVT_W){1'b0}}, status};
      OFS_MASK: rd_mux = {{(WORD_W-EVT_W){1'b0}}, mask};
      OFS_BAD:  rd_mux = {{(WORD_W-BAD_W){1'b0}}, bad_entry};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_req   <= '0;
      halted    <= 1'b0;
      status    <= '0;
      mask      <= '0;
      bad_entry <= '0;
      talm_q    <= '0;
      calm_q    <= '0;
      step_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      step_q    <= step;
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_mux;

      if (wr_en && req_addr == OFS_CTRL) upd_req <= req_wdata[1:0];
      if (wr_en && req_addr == OFS_CTRL && req_wdata[1:0] == 2'b00) halted <= 1'b0;
      else if (ev_set[EV_ACK]) halted <= 1'b1;

      if (wr_en && req_addr == OFS_CLR) status <= (status & ~req_wdata[EVT_W-1:0]) | ev_set;
      else status <= status | ev_set;

      if (wr_en && req_addr == OFS_MSET) mask <= mask | req_wdata[EVT_W-1:0];
      if (wr_en && req_addr == OFS_MCLR) mask <= mask & ~req_wdata[EVT_W-1:0];

      if (wr_en && req_addr == OFS_TIME && halted && upd_req[0]) bad_entry[0] <= !clock_ok(new_clk);
      if (wr_en && req_addr == OFS_CAL && halted && upd_req[1])  bad_entry[1] <= !date_ok(new_date);
      if (wr_en && req_addr == OFS_TALM) begin
        bad_entry[2] <= !talm_ok(req_wdata);
        if (talm_ok(req_wdata)) talm_q <= req_wdata;
      end
      if (wr_en && req_addr == OFS_CALM) begin
        bad_entry[3] <= !calm_ok(req_wdata);
        if (calm_ok(req_wdata)) calm_q <= req_wdata;
      end
    end
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/bcd_rtc_checker.sv
module bcd_rtc_checker
  import rtc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [1:0]       upd_req,
  input logic             wr_en,
  input logic             rd_en,
  input logic             rsp_valid,
  input clock_t           now_clk,
  input date_t            now_date,
  input logic [EVT_W-1:0] status,
  input logic [EVT_W-1:0] mask,
  input logic             irq
);
  AST_SEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_in(now_clk.sec, 8'h00, 8'h59) && bcd_in(now_clk.min, 8'h00, 8'h59)); // R2
  AST_HOUR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_in(now_clk.hour, 8'h00, 8'h23)); // R2
  AST_MDAY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_in(now_date.mday, 8'h01, month_last(now_date.month, now_date.year))); // R3
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req != 2'b00 && !wr_en) |=> $stable(now_clk)); // R4
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[EV_ACK]) |-> $past(upd_req != 2'b00)); // R4
  AST_SEC_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && upd_req == 2'b00) |=> status[EV_SEC]); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0)); // R10
  AST_READ_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid); // R11
endmodule

bind bcd_rtc bcd_rtc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .upd_req(upd_req),
  .wr_en(req_valid && req_write), .rd_en(req_valid && !req_write), .rsp_valid(rsp_valid),
  .now_clk(cur_clk), .now_date(cur_date), .status(status), .mask(mask), .irq(irq)
);

// File: tb/bcd_rtc_test.sv
module bcd_rtc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  localparam logic [5:0] CTRL = 6'h00, MODE = 6'h04, TIME = 6'h08, CAL = 6'h0C, TALM = 6'h10,
                         CALM = 6'h14, STAT = 6'h18, CLR = 6'h1C, MSET = 6'h20, MCLR = 6'h24,
                         MASK = 6'h28, BAD = 6'h2C;

  always #5 clk = ~clk;

  bcd_rtc uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq(irq)
  );

  function automatic logic [31:0] mkcal(input logic [7:0] cent, input logic [7:0] year,
                                        input logic [7:0] mon, input logic [7:0] wday,
                                        input logic [7:0] mday);
    return {2'b00, mday[5:0], wday[2:0], mon[4:0], year, 1'b0, cent[6:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata;
    check("R11 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    req_valid = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    check(req, d, exp);
  endtask

  task automatic one_tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_clock(input logic [31:0] t, input logic [31:0] c);
    bus_wr(CTRL, 32'h3);
    one_tick();
    bus_wr(TIME, t);
    bus_wr(CAL, c);
    bus_wr(CTRL, 32'h0);
    bus_wr(CLR, 32'h1F);
  endtask

  task automatic t_reset();
    check("R11 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 irq", {31'd0, irq}, 32'd0);
    expect_rd("R1 time", TIME, 32'h0);
    expect_rd("R1 calendar", CAL, 32'h01210020);
    expect_rd("R1 status", STAT, 32'h0);
    expect_rd("R1 mask", MASK, 32'h0);
    expect_rd("R1 valid-entry", BAD, 32'h0);
    expect_rd("R11 mode reads zero", MODE, 32'h0);
    expect_rd("R11 unmapped reads zero", 6'h3C, 32'h0);
  endtask

  task automatic t_count();
    for (int i = 0; i < 3; i++) one_tick();
    expect_rd("R2 three ticks", TIME, 32'h00000003);
    expect_rd("R8 second event only", STAT, 32'h04);
  endtask

  task automatic t_rollover();
    set_clock(32'h00105959, mkcal(8'h20, 8'h24, 8'h06, 8'h1, 8'h10));
    one_tick();
    expect_rd("R2 minute carry", TIME, 32'h00110000);
    expect_rd("R8 minute event", STAT, 32'h0C);
    set_clock(32'h00235959, mkcal(8'h20, 8'h24, 8'h02, 8'h3, 8'h28));
    one_tick();
    expect_rd("R2 hour wrap", TIME, 32'h0);
    expect_rd("R3 leap Feb 28->29", CAL, mkcal(8'h20, 8'h24, 8'h02, 8'h4, 8'h29));
    expect_rd("R8 day event", STAT, 32'h1C);
    set_clock(32'h00235959, mkcal(8'h20, 8'h24, 8'h02, 8'h4, 8'h29));
    one_tick();
    expect_rd("R3 leap Feb 29->Mar 1", CAL, mkcal(8'h20, 8'h24, 8'h03, 8'h5, 8'h01));
    set_clock(32'h00235959, mkcal(8'h20, 8'h23, 8'h02, 8'h2, 8'h28));
    one_tick();
    expect_rd("R3 common Feb 28->Mar 1", CAL, mkcal(8'h20, 8'h23, 8'h03, 8'h3, 8'h01));
    set_clock(32'h00235959, mkcal(8'h20, 8'h24, 8'h04, 8'h2, 8'h30));
    one_tick();
    expect_rd("R3 30-day month", CAL, mkcal(8'h20, 8'h24, 8'h05, 8'h3, 8'h01));
    set_clock(32'h00235959, mkcal(8'h20, 8'h99, 8'h12, 8'h7, 8'h31));
    one_tick();
    expect_rd("R3 century and weekday wrap", CAL, mkcal(8'h21, 8'h00, 8'h01, 8'h1, 8'h01));
  endtask

  task automatic t_handshake();
    logic [31:0] c0;
    c0 = mkcal(8'h20, 8'h24, 8'h07, 8'h2, 8'h09);
    set_clock(32'h00070000, c0);
    bus_wr(CTRL, 32'h1);
    expect_rd("R4 no ack before tick", STAT, 32'h0);
    bus_wr(TIME, 32'h00123456);
    expect_rd("R5 write before ack ignored", TIME, 32'h00070000);
    one_tick();
    expect_rd("R4 ack after tick", STAT, 32'h01);
    one_tick();
    expect_rd("R4 frozen while requested", TIME, 32'h00070000);
    bus_wr(TIME, 32'h00123456);
    expect_rd("R5 time load while acked", TIME, 32'h00123456);
    bus_wr(CAL, mkcal(8'h20, 8'h25, 8'h01, 8'h1, 8'h01));
    expect_rd("R5 calendar write without its request", CAL, c0);
    bus_wr(CTRL, 32'h0);
    one_tick();
    expect_rd("R4 counting resumes", TIME, 32'h00123457);
  endtask

  task automatic t_invalid();
    set_clock(32'h00120000, mkcal(8'h20, 8'h24, 8'h02, 8'h4, 8'h10));
    bus_wr(CTRL, 32'h3);
    one_tick();
    bus_wr(TIME, 32'h00250000);
    expect_rd("R6 bad hour flagged", BAD, 32'h1);
    expect_rd("R6 bad hour not loaded", TIME, 32'h00120000);
    bus_wr(CAL, mkcal(8'h20, 8'h24, 8'h02, 8'h5, 8'h30));
    expect_rd("R6 Feb 30 flagged", BAD, 32'h3);
    bus_wr(CAL, mkcal(8'h20, 8'h23, 8'h02, 8'h5, 8'h29));
    expect_rd("R6 Feb 29 in common year not loaded", CAL, mkcal(8'h20, 8'h24, 8'h02, 8'h4, 8'h10));
    bus_wr(TIME, 32'h00080000);
    expect_rd("R6 valid time clears flag", BAD, 32'h2);
    bus_wr(CAL, mkcal(8'h20, 8'h24, 8'h02, 8'h4, 8'h29));
    expect_rd("R6 valid leap date clears flag", BAD, 32'h0);
    bus_wr(TALM, 32'h000000FA);
    bus_wr(CALM, 32'h00930000);
    expect_rd("R6 bad alarms flagged", BAD, 32'hC);
    bus_wr(TALM, 32'h00000083);
    bus_wr(CALM, 32'h0);
    expect_rd("R6 good alarms clear flags", BAD, 32'h0);
    bus_wr(CTRL, 32'h0);
    bus_wr(CLR, 32'h1F);
  endtask

  task automatic t_alarm();
    logic [31:0] c15;
    c15 = mkcal(8'h20, 8'h24, 8'h05, 8'h3, 8'h15);
    bus_wr(TALM, 32'h00000083);
    bus_wr(CALM, 32'h0);
    set_clock(32'h00120000, c15);
    one_tick(); one_tick();
    expect_rd("R7 no alarm at sec 02", STAT, 32'h04);
    one_tick();
    expect_rd("R7 alarm at sec 03", STAT, 32'h06);
    bus_wr(TALM, 32'h0000C583);
    set_clock(32'h00120002, c15);
    one_tick();
    expect_rd("R7 minute mismatch blocks", STAT, 32'h04);
    bus_wr(TALM, 32'h00000083);
    bus_wr(CALM, 32'h95000000);
    set_clock(32'h00120002, c15);
    one_tick();
    expect_rd("R7 date match fires", STAT, 32'h06);
    bus_wr(CALM, 32'h96000000);
    set_clock(32'h00120002, c15);
    one_tick();
    expect_rd("R7 date mismatch blocks", STAT, 32'h04);
    bus_wr(TALM, 32'h00000003);
    bus_wr(CALM, 32'h0);
    set_clock(32'h00120002, c15);
    one_tick();
    expect_rd("R7 no enables never fires", STAT, 32'h04);
  endtask

  task automatic t_irq();
    bus_wr(CLR, 32'h1F);
    bus_wr(MSET, 32'h04);
    expect_rd("R10 mask set", MASK, 32'h04);
    check("R10 irq idle", {31'd0, irq}, 32'd0);
    one_tick();
    check("R10 irq on masked event", {31'd0, irq}, 32'd1);
    bus_wr(MCLR, 32'h04);
    check("R10 irq after disable", {31'd0, irq}, 32'd0);
    expect_rd("R10 mask cleared", MASK, 32'h0);
    bus_wr(MSET, 32'h06);
    check("R10 irq re-enabled", {31'd0, irq}, 32'd1);
    bus_wr(CLR, 32'h04);
    check("R9 irq after clear", {31'd0, irq}, 32'd0);
    expect_rd("R10 mask two bits", MASK, 32'h06);
    set_clock(32'h00105959, mkcal(8'h20, 8'h24, 8'h06, 8'h1, 8'h10));
    one_tick();
    bus_wr(CLR, 32'h08);
    expect_rd("R9 only written bits cleared", STAT, 32'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_rollover();
    t_handshake();
    t_invalid();
    t_alarm();
    t_irq();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule